// File: doc/BRIEF.md
# Diode Bridge Conduction Sequencer

This block decides, once per model time step, which diodes of a three-phase diode bridge feeding a DC link are conducting. It is meant for a fixed-point real-time plant model. The arithmetic that integrates inductor currents and the link voltage sits outside this block. Each strobed sample brings in the three line-to-line voltages, the link voltage, the three phase inductor currents and an estimate of the stray-inductance voltage of the phase that is handing over current. From these the block produces six diode conduction bits. It also produces a flag that tells the downstream arithmetic whether to use the two-diode equations or the three-diode commutation equations. A per-phase force-to-zero command tells the current integrators which phases carry no current.

The state is held in one of three modes. In idle, no diode conducts. In a single pair, one upper and one lower diode conduct. In commutation, three diodes conduct while current moves from an outgoing phase to an incoming one. The six candidate pairs are ranked by their line voltage. Entry into conduction and into commutation is gated by comparisons against the link voltage. Exit is driven by phase currents collapsing into a configurable dead band around zero.

Top module: `rect_cond_seq`

## Requirements
- R1: While reset is high and after it is released, the block is idle: all conduction bits are 0, the commutation flag is 0 and all three force-to-zero bits are 1.
- R2: When idle, a strobed sample makes the pair with the largest line voltage conduct if that voltage is strictly greater than the link voltage; if it is equal or lower, the block stays idle. Pairs are numbered 0..5 as (A+,B-), (B+,C-), (C+,A-), (B+,A-), (C+,B-), (A+,C-), with line voltages vl_ab, vl_bc, vl_ca and their negations. Conduction bit 2p is the upper diode and bit 2p+1 is the lower diode of phase p, where A=0, B=1 and C=2.
- R3: When two pairs tie for the largest line voltage, the lower pair number wins.
- R4: A single pair stays on while its upper-phase current is above +DB and its lower-phase current is below -DB. Otherwise it returns to idle. Phase current is positive when it flows from the source into the bridge.
- R5: From a single pair, if the largest line voltage moves to a pair that shares exactly one diode and exceeds the link voltage plus the stray voltage estimate (strictly), three diodes conduct and the commutation flag is 1. An equal value does not start commutation.
- R6: From a single pair, a new largest pair that shares no diode with it causes no change.
- R7: During commutation, three diodes stay on while the outgoing phase still carries current in its original direction beyond the dead band. Once that current falls into the band or reverses, only the incoming pair conducts and the flag clears. The outgoing phase is the one whose diode is not shared.
- R8: In a conducting mode, if all three currents are within the dead band, the block goes idle; this takes priority over every other transition.
- R9: Force-to-zero bit p is 1 exactly when neither diode of phase p conducts.
- R10: Without a sample strobe, the state and all outputs hold.
- R11: Outputs are registered; they change on the clock edge that takes the strobe, together with the commutation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle strobe marking a new model step |
| vl_ab | input | VW | Line voltage A minus B, signed |
| vl_bc | input | VW | Line voltage B minus C, signed |
| vl_ca | input | VW | Line voltage C minus A, signed |
| v_link | input | VW | DC-link voltage, signed |
| v_stray | input | VW | Stray-inductance voltage estimate of the outgoing phase, signed |
| cur_a | input | IW | Phase A inductor current, signed |
| cur_b | input | IW | Phase B inductor current, signed |
| cur_c | input | IW | Phase C inductor current, signed |
| diode_on | output | 6 | Conduction bits, 2p upper and 2p+1 lower of phase p |
| overlap | output | 1 | 1 while three diodes conduct |
| force_zero | output | 3 | Per-phase command to clamp the inductor current to zero |

## Verification
The hardest state to reach is commutation, followed by a clean exit from it. Reaching it takes a prior pair in conduction with live currents of the right signs. The largest line voltage must then move to a neighbour that shares one diode, and its margin over link plus stray voltage must be controlled exactly. The stimulus builds this up step by step. First a pair is started from idle. Then the line voltages are rotated so that a sharing neighbour is at exactly the threshold, which must not trigger commutation, and then one unit above it, which must. Commutation is entered both through a shared upper diode and through a shared lower diode. One exit uses the outgoing current entering the dead band, another uses the current reversing. A third case collapses all currents to check that the idle transition takes priority.

// File: rtl/rect_seq_pkg.sv
package rect_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_NORM = 2'd1,
    ST_OVL  = 2'd2
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic [2:0] cur;   // pair conducting (outgoing pair in overlap)
    logic [2:0] nxt;   // incoming pair in overlap
  } cstate_t;

  localparam int NPAIR = 6;

  // upper-diode phase of pair k
  function automatic logic [1:0] top_ph(input logic [2:0] k);
    case (k)
      3'd0:    top_ph = 2'd0;
      3'd1:    top_ph = 2'd1;
      3'd2:    top_ph = 2'd2;
      3'd3:    top_ph = 2'd1;
      3'd4:    top_ph = 2'd2;
      default: top_ph = 2'd0;
    endcase
  endfunction

  // lower-diode phase of pair k
  function automatic logic [1:0] bot_ph(input logic [2:0] k);
    case (k)
      3'd0:    bot_ph = 2'd1;
      3'd1:    bot_ph = 2'd2;
      3'd2:    bot_ph = 2'd0;
      3'd3:    bot_ph = 2'd0;
      3'd4:    bot_ph = 2'd1;
      default: bot_ph = 2'd2;
    endcase
  endfunction

  function automatic logic [5:0] pair_bits(input logic [2:0] k);
    logic [5:0] b;
    b = '0;
    b[{top_ph(k), 1'b0}] = 1'b1;
    b[{bot_ph(k), 1'b1}] = 1'b1;
    return b;
  endfunction

endpackage

// File: rtl/rect_linemax.sv
module rect_linemax
  import rect_seq_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic signed [VW-1:0] vl_ab,
  input  logic signed [VW-1:0] vl_bc,
  input  logic signed [VW-1:0] vl_ca,
  output logic        [2:0]    k_max,
  output logic signed [VW:0]   v_max
);

  logic signed [VW:0] line [NPAIR];

  assign line[0] = VW'(vl_ab) <<< 0;
  assign line[1] = VW'(vl_bc) <<< 0;
  assign line[2] = VW'(vl_ca) <<< 0;
  assign line[3] = -{vl_ab[VW-1], vl_ab};
  assign line[4] = -{vl_bc[VW-1], vl_bc};
  assign line[5] = -{vl_ca[VW-1], vl_ca};

  always_comb begin
    k_max = 3'd0;
    v_max = line[0];
    for (int k = 1; k < NPAIR; k++) begin
      if (line[k] > v_max) begin   // strict: lowest index wins a tie
        k_max = 3'(k);
        v_max = line[k];
      end
    end
  end

endmodule

// File: rtl/rect_zero_band.sv
module rect_zero_band #(
  parameter int IW = 16,
  parameter int DB = 4
) (
  input  logic signed [IW-1:0] cur,
  output logic                 pos,
  output logic                 neg
);

  localparam logic signed [IW-1:0] BAND = IW'(DB);

  assign pos = (cur > BAND);
  assign neg = (cur < -BAND);

endmodule

// File: rtl/rect_step_fsm.sv
module rect_step_fsm
  import rect_seq_pkg::*;
#(
  parameter int VW = 16
) (
  input  cstate_t              st,
  input  logic        [2:0]    k_max,
  input  logic signed [VW:0]   v_max,
  input  logic signed [VW-1:0] v_link,
  input  logic signed [VW-1:0] v_stray,
  input  logic        [2:0]    pos,
  input  logic        [2:0]    neg,
  output cstate_t              ns
);

  localparam int XW = VW + 2;

  logic signed [XW-1:0] vmax_x, link_x, thr_x;
  logic                 all_zero;
  logic [1:0]           tc, bc, tn, bn, out_ph;
  logic                 share_top, share_one, pair_dead, out_dead;

  assign vmax_x   = XW'(v_max);
  assign link_x   = XW'(v_link);
  assign thr_x    = XW'(v_link) + XW'(v_stray);
  assign all_zero = ~|(pos | neg);

  assign tc = top_ph(st.cur);
  assign bc = bot_ph(st.cur);
  assign tn = top_ph(k_max);
  assign bn = bot_ph(k_max);

  // pair conduction ends when currents leave their forward direction
  assign pair_dead = !pos[tc] || !neg[bc];
  assign share_one = (k_max != st.cur) && ((tc == tn) || (bc == bn));

  // outgoing phase during overlap: the unshared diode of the old pair
  assign share_top = (top_ph(st.cur) == top_ph(st.nxt));
  assign out_ph    = share_top ? bot_ph(st.cur) : top_ph(st.cur);
  assign out_dead  = share_top ? !neg[out_ph] : !pos[out_ph];

  always_comb begin
    ns = st;
    unique case (st.mode)
      ST_OFF: begin
        if (vmax_x > link_x) begin
          ns.mode = ST_NORM;
          ns.cur  = k_max;
          ns.nxt  = k_max;
        end
      end
      ST_NORM: begin
        if (all_zero || pair_dead) begin
          ns.mode = ST_OFF;
        end else if (share_one && (vmax_x > thr_x)) begin
          ns.mode = ST_OVL;
          ns.nxt  = k_max;
        end
      end
      ST_OVL: begin
        if (all_zero) begin
          ns.mode = ST_OFF;
        end else if (out_dead) begin
          ns.mode = ST_NORM;
          ns.cur  = st.nxt;
        end
      end
      default: ns.mode = ST_OFF;
    endcase
  end

endmodule

// File: rtl/rect_cond_seq.sv
module rect_cond_seq
  import rect_seq_pkg::*;
#(
  parameter int VW = 16,
  parameter int IW = 16,
  parameter int DB = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic signed [VW-1:0] vl_ab,
  input  logic signed [VW-1:0] vl_bc,
  input  logic signed [VW-1:0] vl_ca,
  input  logic signed [VW-1:0] v_link,
  input  logic signed [VW-1:0] v_stray,
  input  logic signed [IW-1:0] cur_a,
  input  logic signed [IW-1:0] cur_b,
  input  logic signed [IW-1:0] cur_c,
  output logic        [5:0]    diode_on,
  output logic                 overlap,
  output logic        [2:0]    force_zero
);

  cstate_t            st_q, st_d;
  logic [2:0]         k_max;
  logic signed [VW:0] v_max;
  logic [2:0]         pos, neg;
  logic signed [IW-1:0] cur_v [3];
  logic [5:0]         sw_d;
  logic [2:0]         fz_d;

  assign cur_v[0] = cur_a;
  assign cur_v[1] = cur_b;
  assign cur_v[2] = cur_c;

  rect_linemax #(.VW(VW)) u_max (
    .vl_ab (vl_ab),
    .vl_bc (vl_bc),
    .vl_ca (vl_ca),
    .k_max (k_max),
    .v_max (v_max)
  );

  for (genvar p = 0; p < 3; p++) begin : g_band
    rect_zero_band #(.IW(IW), .DB(DB)) u_band (
      .cur (cur_v[p]),
      .pos (pos[p]),
      .neg (neg[p])
    );
  end

  rect_step_fsm #(.VW(VW)) u_fsm (
    .st      (st_q),
    .k_max   (k_max),
    .v_max   (v_max),
    .v_link  (v_link),
    .v_stray (v_stray),
    .pos     (pos),
    .neg     (neg),
    .ns      (st_d)
  );

  always_comb begin
    case (st_d.mode)
      ST_NORM: sw_d = pair_bits(st_d.cur);
      ST_OVL:  sw_d = pair_bits(st_d.cur) | pair_bits(st_d.nxt);
      default: sw_d = '0;
    endcase
    for (int p = 0; p < 3; p++) fz_d[p] = ~(sw_d[2*p] | sw_d[2*p+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= '{mode: ST_OFF, cur: 3'd0, nxt: 3'd0};
      diode_on   <= '0;
      overlap    <= 1'b0;
      force_zero <= 3'b111;
    end else if (sample_en) begin
      st_q       <= st_d;
      diode_on   <= sw_d;
      overlap    <= (st_d.mode == ST_OVL);
      force_zero <= fz_d;
    end
  end

endmodule

// File: rtl/rect_cond_seq_chk.sv
module rect_cond_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sample_en,
  input logic [5:0] diode_on,
  input logic       overlap,
  input logic [2:0] force_zero
);

  // R1: idle outputs right after reset release
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (diode_on == 6'd0 && !overlap && force_zero == 3'b111));

  // R2: never both diodes of one phase
  a_r2_no_leg_short: assert property (@(posedge clk) disable iff (rst)
    (diode_on[1:0] != 2'b11 && diode_on[3:2] != 2'b11 && diode_on[5:4] != 2'b11));

  // R5: commutation means exactly three diodes, otherwise zero or two
  a_r5_three_in_overlap: assert property (@(posedge clk) disable iff (rst)
    overlap |-> ($countones(diode_on) == 3));
  a_r5_pair_or_idle: assert property (@(posedge clk) disable iff (rst)
    !overlap |-> ($countones(diode_on) == 2 || diode_on == 6'd0));

  // R5: commutation only entered from a conducting pair
  a_r5_entry_from_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(overlap) |-> ($countones($past(diode_on)) == 2));

  // R7: leaving commutation lands on a pair or idle
  a_r7_exit_shape: assert property (@(posedge clk) disable iff (rst)
    $fell(overlap) |-> ($countones(diode_on) == 2 || diode_on == 6'd0));

  // R9: clamp command matches blocked phases
  a_r9_clamp_match: assert property (@(posedge clk) disable iff (rst)
    (force_zero[0] == ~|diode_on[1:0]) && (force_zero[1] == ~|diode_on[3:2])
    && (force_zero[2] == ~|diode_on[5:4]));

  // R10: no strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(diode_on) && $stable(overlap) && $stable(force_zero)));

endmodule

bind rect_cond_seq rect_cond_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sample_en  (sample_en),
  .diode_on   (diode_on),
  .overlap    (overlap),
  .force_zero (force_zero)
);

// File: tb/rect_cond_seq_test.sv
module rect_cond_seq_test;

  localparam int VW = 16;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic signed [VW-1:0] vl_ab = '0, vl_bc = '0, vl_ca = '0, v_link = '0, v_stray = '0;
  logic signed [IW-1:0] cur_a = '0, cur_b = '0, cur_c = '0;
  logic [5:0] diode_on;
  logic       overlap;
  logic [2:0] force_zero;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [5:0] sw;
    logic       ov;
    logic [2:0] fz;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;   // 50 MHz

  rect_cond_seq #(.VW(VW), .IW(IW), .DB(4)) uut (
    .clk, .rst, .sample_en, .vl_ab, .vl_bc, .vl_ca, .v_link, .v_stray,
    .cur_a, .cur_b, .cur_c, .diode_on, .overlap, .force_zero
  );

  task automatic compare(input exp_t e);
    n_run++;
    if (diode_on !== e.sw || overlap !== e.ov || force_zero !== e.fz) begin
      n_fail++;
      $display("FAIL %s: got sw=%b ov=%b fz=%b, expected sw=%b ov=%b fz=%b",
               e.tag, diode_on, overlap, force_zero, e.sw, e.ov, e.fz);
    end
  endtask

  // monitor: result registered on the strobed edge
  always @(posedge clk) begin
    if (!rst && sample_en) begin
      #2;
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: output with no expected item");
      end else begin
        compare(exp_q.pop_front());
      end
    end
  end

  task automatic step(input int ab, input int bc, input int ca, input int lk,
                      input int sy, input int ia, input int ib, input int ic,
                      input logic [5:0] sw, input logic ov, input logic [2:0] fz,
                      input string tag);
    exp_t e;
    @(negedge clk);
    vl_ab = VW'(ab); vl_bc = VW'(bc); vl_ca = VW'(ca);
    v_link = VW'(lk); v_stray = VW'(sy);
    cur_a = IW'(ia); cur_b = IW'(ib); cur_c = IW'(ic);
    e.sw = sw; e.ov = ov; e.fz = fz; e.tag = tag;
    exp_q.push_back(e);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    e = '{sw: 6'b0, ov: 1'b0, fz: 3'b111, tag: "R1 in reset"};
    compare(e);
    rst = 1'b0;
    @(negedge clk);
    e.tag = "R1 after reset";
    compare(e);

    // R2: max equal to link voltage -> stay idle
    step(100, -30, -70, 100, 0, 0, 0, 0, 6'b000000, 1'b0, 3'b111, "R2 equal stays idle");
    // R2: pair 0 (A+,B-) starts
    step(120, -30, -90, 100, 0, 0, 0, 0, 6'b001001, 1'b0, 3'b100, "R2 start pair0");
    // R4/R5: neighbour pair5 at exactly link+stray -> no commutation
    step(80, 10, -90, 80, 10, 50, -50, 0, 6'b001001, 1'b0, 3'b100, "R4 R5 equal threshold holds");
    // R5: one above threshold, shared upper A -> A+,B-,C-
    step(80, 10, -90, 80, 9, 50, -50, 0, 6'b101001, 1'b1, 3'b000, "R5 enter commutation shared top");
    // R7: outgoing B current into band -> pair5 (A+,C-)
    step(80, 10, -90, 80, 9, 50, -4, -46, 6'b100001, 1'b0, 3'b010, "R7 exit to incoming pair");
    // R6: new max pair3 shares nothing with pair5 -> no change
    step(-200, 100, 100, 80, 0, 50, 0, -50, 6'b100001, 1'b0, 3'b010, "R6 unshared max ignored");

    // R10: no strobe while inputs would cause idle
    @(negedge clk);
    cur_a = '0; cur_b = '0; cur_c = '0; vl_ab = 16'sd500;
    repeat (3) @(negedge clk);
    e = '{sw: 6'b100001, ov: 1'b0, fz: 3'b010, tag: "R10 hold without strobe"};
    compare(e);

    // R4: upper-phase current at band edge -> idle
    step(-200, 100, 100, 80, 0, 4, 0, -50, 6'b000000, 1'b0, 3'b111, "R4 pair current ends");
    // R3: tie between pair0 and pair5 -> pair0
    step(150, 0, -150, 100, 0, 0, 0, 0, 6'b001001, 1'b0, 3'b100, "R3 tie lowest index");
    // enter commutation again from pair0
    step(80, 10, -90, 50, 0, 50, -50, 0, 6'b101001, 1'b1, 3'b000, "R5 re-enter commutation");
    // R8: all currents in band -> idle, over commutation exit
    step(80, 10, -90, 50, 0, 2, -1, 0, 6'b000000, 1'b0, 3'b111, "R8 all zero priority");
    // R2: pair4 (C+,B-)
    step(100, -200, 100, 150, 0, 0, 0, 0, 6'b011000, 1'b0, 3'b001, "R2 start pair4");
    // R5: max moves to pair0 sharing B- ; 300 > 150+100
    step(300, -250, -50, 150, 100, 0, -60, 60, 6'b011001, 1'b1, 3'b000, "R5 enter commutation shared bottom");
    // R7: outgoing C still forward -> stay
    step(300, -250, -50, 150, 100, 30, -60, 30, 6'b011001, 1'b1, 3'b000, "R7 commutation holds");
    // R7: outgoing C reverses -> pair0
    step(300, -250, -50, 150, 100, 60, -50, -10, 6'b001001, 1'b0, 3'b100, "R7 reversal ends commutation R11");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule